// File: doc/BRIEF.md
# Trip Threshold Calibration Sequencer

This block trims the programmable trip threshold of one of three monitored voltage channels. It runs a closed measure-and-correct loop until the measured trip point lies close enough to a target. Channel 1 is the main supply. Channels 2 and 3 are auxiliary monitor inputs. The channel is chosen by a 2-bit index. The block does not drive any analog signal itself. It drives a DAC code that sets the voltage applied to the selected channel, and it reads the monitor's comparator output. Threshold changes are requested from an external programming engine through two command lines, "reset threshold" and "set higher threshold", and the engine answers each with an acknowledge.

A run begins on a start pulse. The block first compares the target with the threshold code that is programmed now. A threshold can only be raised by programming, so when the target lies below the present code the block clears the threshold first. It then applies the corrected target voltage and requests a set-higher. Next it finds the actual trip point: it ramps the DAC code down from full scale and stops at the code where the comparator reports that the voltage is no longer above the threshold.

The error is the actual trip code minus the target. When its magnitude is below the allowed limit, the run ends with done. Otherwise the applied code is corrected by subtracting the error, and the block programs again. A positive error is first undone with a threshold reset. A negative error is raised directly. If no convergence occurs within an iteration limit, the run ends with fail.

Top module: `trip_cal_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, done, fail, cmd_reset and cmd_set_high are 0 and dac_code is 0.
- R2: A start pulse is accepted only while busy is 0 and chan_sel is 1, 2 or 3. A start with chan_sel = 0, and any start while busy, has no effect. dac_chan shows the channel latched at the accepted start.
- R3: When target_code is less than present_code at the accepted start, exactly one threshold reset is requested before the first set-higher. Otherwise no reset is requested before the first set-higher.
- R4: Each programming step drives dac_code to the applied code. The applied code is target_code on the first pass and the corrected value afterwards. The step waits settle_cnt+1 cycles, then raises cmd_set_high.
- R5: cmd_reset and cmd_set_high are never high together. Each stays high until the cycle in which cmd_ack is sampled high, and is low in the next cycle.
- R6: Measurement starts at the full-scale code (all ones) and decreases dac_code by one per step. Each step is held settle_cnt+1 cycles before cmp_out is sampled. The first code at which cmp_out is 0 is recorded on meas_code. If cmp_out is still 1 at code 0, code 0 is recorded.
- R7: Let err = meas_code − target_code, computed as a signed value. When |err| < max_err, the run ends with done = 1.
- R8: When err > 0 and the run has not converged, a threshold reset is requested. The block then reprograms with the applied code set to the old applied code minus err, saturated to the range 0 to full scale.
- R9: When err ≤ 0 and the run has not converged, the block reprograms without a reset. The applied code is set to the old applied code minus err, saturated to full scale.
- R10: When ITER_MAX measurements complete without convergence, the run ends with fail = 1.
- R11: busy is 1 from the cycle after an accepted start until the run ends. done and fail are cleared by an accepted start. They are never both 1, and each holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a calibration run |
| chan_sel | input | 2 | Channel index 1..3; 0 is invalid |
| target_code | input | CODE_W | Desired trip threshold code |
| present_code | input | CODE_W | Threshold code programmed now |
| max_err | input | CODE_W | Allowed error magnitude (exclusive bound) |
| settle_cnt | input | SETTLE_W | Extra settle cycles after each DAC change |
| cmp_out | input | 1 | Comparator: 1 while the applied voltage is above the trip point |
| cmd_ack | input | 1 | Acknowledge from the programming engine |
| dac_code | output | CODE_W | Code for the DAC that drives the channel voltage |
| dac_chan | output | 2 | Channel the DAC voltage is routed to |
| cmd_reset | output | 1 | Threshold reset request, held until acknowledged |
| cmd_set_high | output | 1 | Set-higher request, held until acknowledged |
| meas_code | output | CODE_W | Last measured trip code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run converged |
| fail | output | 1 | Iteration limit reached |

## Verification
The loop runs against a behavioural monitor in the bench. In that model a reset clears the channel threshold to 0, and a set-higher raises the threshold to the applied code plus a programming offset, but never lowers it. The bench sweeps targets across the code range and uses both a low and a high present code, so runs start with and without the initial reset. Negative offsets exercise the reprogram-only path. Positive offsets exercise the reset-and-reprogram path, and a zero offset converges on the first pass. Large offsets near either end of the code range push the corrected code into saturation and end in fail. A zero error limit can never converge and checks the iteration limit. Acknowledge delays are varied, and starts with channel 0 or during a run are injected, to show that they leave the result unchanged.

// File: rtl/trip_cal_pkg.sv
// Shared types for the trip threshold calibration sequencer.
// Assumes: consumers import the package; encoding of the state is internal.
package trip_cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RST_CMD   = 3'd1,
        ST_PROG_LOAD = 3'd2,
        ST_PROG_WAIT = 3'd3,
        ST_SET_CMD   = 3'd4,
        ST_MEAS_LOAD = 3'd5,
        ST_MEAS_WAIT = 3'd6,
        ST_EVAL      = 3'd7
    } cal_state_t;

endpackage

// File: rtl/settle_timer.sv
// Settle timer: a load pulse arms a down counter with a cycle count. 'expired'
// rises settle count + 1 cycles after the load pulse and drops one cycle later.
// Assumes: load is a single-cycle pulse, and no new load arrives while the
// owner waits for expiry.
module settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Count down from the loaded value while the timer is armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= count;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry is the armed timer at zero.
    assign expired = run_q && (cnt_q == '0);

    // R4 / R6: an armed timer decrements by one and stays armed until it reaches zero.
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !load) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/trip_err_calc.sv
// Error evaluation: forms the signed error of the measured trip code
// against the target, decides convergence, and computes the next applied
// code as (applied - error), saturated to 0 .. full scale.
// Assumes: all codes are unsigned CODE_W-bit values; purely combinational.
module trip_err_calc #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] meas,
    input  logic [CODE_W-1:0] target,
    input  logic [CODE_W-1:0] applied,
    input  logic [CODE_W-1:0] limit,
    output logic              converged,
    output logic              err_pos,
    output logic [CODE_W-1:0] next_applied
);

    localparam int EW = CODE_W + 2;
    localparam logic signed [EW-1:0] FULL_S = EW'((1 << CODE_W) - 1);

    logic signed [EW-1:0] err;
    logic signed [EW-1:0] mag;
    logic signed [EW-1:0] corr;

    // Signed error and its magnitude.
    always_comb begin
        err = $signed({2'b00, meas}) - $signed({2'b00, target});
        mag = (err < 0) ? -err : err;
    end

    // Convergence and sign decisions.
    assign converged = (mag < $signed({2'b00, limit}));
    assign err_pos   = (err > 0);

    // Corrected applied code with saturation to the DAC range.
    always_comb begin
        corr = $signed({2'b00, applied}) - err;
        if (corr < 0)            next_applied = '0;
        else if (corr > FULL_S)  next_applied = '1;
        else                     next_applied = corr[CODE_W-1:0];
    end

endmodule

// File: rtl/trip_cal_seq.sv
// Trip threshold calibration sequencer (top). Per run it: optionally
// requests a threshold reset, programs with the applied code, ramps the DAC
// down from full scale to locate the trip point, evaluates the error and
// corrects, for at most ITER_MAX measurements.
// Assumes: cmd_ack arrives only while a command is high; cmp_out is 1 while
// the applied voltage is above the channel's trip point and is valid after
// the settle window.
module trip_cal_seq
    import trip_cal_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SETTLE_W = 8,
    parameter int ITER_MAX = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          chan_sel,
    input  logic [CODE_W-1:0]   target_code,
    input  logic [CODE_W-1:0]   present_code,
    input  logic [CODE_W-1:0]   max_err,
    input  logic [SETTLE_W-1:0] settle_cnt,
    input  logic                cmp_out,
    input  logic                cmd_ack,
    output logic [CODE_W-1:0]   dac_code,
    output logic [1:0]          dac_chan,
    output logic                cmd_reset,
    output logic                cmd_set_high,
    output logic [CODE_W-1:0]   meas_code,
    output logic                busy,
    output logic                done,
    output logic                fail
);

    localparam int IT_W = $clog2(ITER_MAX + 1);
    localparam logic [IT_W-1:0] ITER_LAST = IT_W'(ITER_MAX - 1);

    cal_state_t          state_q;
    logic [CODE_W-1:0]   target_q;
    logic [CODE_W-1:0]   limit_q;
    logic [CODE_W-1:0]   apply_q;
    logic [CODE_W-1:0]   ramp_q;
    logic [CODE_W-1:0]   dac_q;
    logic [CODE_W-1:0]   meas_q;
    logic [1:0]          chan_q;
    logic [IT_W-1:0]     iter_q;
    logic                done_q;
    logic                fail_q;
    logic                accept;
    logic                tmr_load;
    logic                tmr_exp;
    logic                converged;
    logic                err_pos;
    logic [CODE_W-1:0]   next_apply;

    // Start acceptance: idle and a valid channel index.
    assign accept = start && (state_q == ST_IDLE) && (chan_sel != 2'd0);

    // Arm the settle timer whenever a new DAC code is loaded.
    assign tmr_load = (state_q == ST_PROG_LOAD) || (state_q == ST_MEAS_LOAD);

    settle_timer #(.CNT_W(SETTLE_W)) settle_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .count   (settle_cnt),
        .expired (tmr_exp)
    );

    trip_err_calc #(.CODE_W(CODE_W)) err_i (
        .meas         (meas_q),
        .target       (target_q),
        .applied      (apply_q),
        .limit        (limit_q),
        .converged    (converged),
        .err_pos      (err_pos),
        .next_applied (next_apply)
    );

    // Main sequencing state machine with its data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target_q <= '0;
            limit_q  <= '0;
            apply_q  <= '0;
            ramp_q   <= '0;
            dac_q    <= '0;
            meas_q   <= '0;
            chan_q   <= 2'd0;
            iter_q   <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        target_q <= target_code;
                        limit_q  <= max_err;
                        apply_q  <= target_code;
                        chan_q   <= chan_sel;
                        iter_q   <= '0;
                        done_q   <= 1'b0;
                        fail_q   <= 1'b0;
                        state_q  <= (target_code < present_code) ? ST_RST_CMD : ST_PROG_LOAD;
                    end
                end
                ST_RST_CMD: begin
                    if (cmd_ack) state_q <= ST_PROG_LOAD;
                end
                ST_PROG_LOAD: begin
                    dac_q   <= apply_q;
                    state_q <= ST_PROG_WAIT;
                end
                ST_PROG_WAIT: begin
                    if (tmr_exp) state_q <= ST_SET_CMD;
                end
                ST_SET_CMD: begin
                    if (cmd_ack) begin
                        ramp_q  <= '1;
                        state_q <= ST_MEAS_LOAD;
                    end
                end
                ST_MEAS_LOAD: begin
                    dac_q   <= ramp_q;
                    state_q <= ST_MEAS_WAIT;
                end
                ST_MEAS_WAIT: begin
                    if (tmr_exp) begin
                        if (!cmp_out || ramp_q == '0) begin
                            meas_q  <= ramp_q;
                            state_q <= ST_EVAL;
                        end else begin
                            ramp_q  <= ramp_q - 1'b1;
                            state_q <= ST_MEAS_LOAD;
                        end
                    end
                end
                ST_EVAL: begin
                    if (converged) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (iter_q == ITER_LAST) begin
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        apply_q <= next_apply;
                        iter_q  <= iter_q + 1'b1;
                        state_q <= err_pos ? ST_RST_CMD : ST_PROG_LOAD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output mapping.
    assign dac_code     = dac_q;
    assign dac_chan     = chan_q;
    assign meas_code    = meas_q;
    assign cmd_reset    = (state_q == ST_RST_CMD);
    assign cmd_set_high = (state_q == ST_SET_CMD);
    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign fail         = fail_q;

    // R5: the two command requests are exclusive.
    a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_reset && cmd_set_high));

    // R5: a reset request is held until it is acknowledged.
    a_r5_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset && !cmd_ack) |=> cmd_reset);

    // R5: a set-higher request drops right after its acknowledge.
    a_r5_set_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_set_high && cmd_ack) |=> !cmd_set_high);

    // R6: successive measurement codes step down by exactly one.
    a_r6_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEAS_WAIT && tmr_exp && cmp_out && ramp_q != '0)
        |=> (ramp_q == $past(ramp_q) - 1'b1));

    // R7: a converged evaluation ends the run with done.
    a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && converged) |=> (done && !busy && !fail));

    // R10: the iteration counter never passes the limit.
    a_r10_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= ITER_LAST);

    // R11: done and fail are exclusive.
    a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R2: the latched channel is stable for the whole run.
    a_r2_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dac_chan));

endmodule

// File: tb/trip_cal_seq_tb_top.sv
`timescale 1ns/1ps
// Bench for the calibration sequencer: a behavioural monitor and programming
// engine model, a sweep over target, present code, offset and error limit,
// and an arithmetic reference of the expected run outcome.
module trip_cal_seq_tb_top;

    localparam int CW   = 6;
    localparam int SW   = 4;
    localparam int ITM  = 6;
    localparam int FULL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    chan_sel = 2'd0;
    logic [CW-1:0] target_code = '0;
    logic [CW-1:0] present_code = '0;
    logic [CW-1:0] max_err = '0;
    logic [SW-1:0] settle_cnt = SW'(1);
    logic          cmp_out;
    logic          cmd_ack = 1'b0;
    logic [CW-1:0] dac_code;
    logic [1:0]    dac_chan;
    logic          cmd_reset;
    logic          cmd_set_high;
    logic [CW-1:0] meas_code;
    logic          busy;
    logic          done;
    logic          fail;

    int n_chk = 0;
    int n_bad = 0;
    int trip_m [4];
    int off_g = 0;
    int ack_dly = 0;
    int n_rst = 0;
    int n_set = 0;
    int last_prog = 0;
    int n_viol = 0;

    always #2.5 clk = ~clk;

    trip_cal_seq #(.CODE_W(CW), .SETTLE_W(SW), .ITER_MAX(ITM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .target_code(target_code), .present_code(present_code), .max_err(max_err),
        .settle_cnt(settle_cnt), .cmp_out(cmp_out), .cmd_ack(cmd_ack),
        .dac_code(dac_code), .dac_chan(dac_chan), .cmd_reset(cmd_reset),
        .cmd_set_high(cmd_set_high), .meas_code(meas_code), .busy(busy),
        .done(done), .fail(fail)
    );

    // Monitor model: comparator high while the applied code is above the trip.
    assign cmp_out = (int'(dac_code) > trip_m[dac_chan]);

    function automatic int sat(input int v);
        return (v < 0) ? 0 : ((v > FULL) ? FULL : v);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Programming engine model: delayed acknowledge and threshold update.
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_reset && cmd_set_high) n_viol++;
            if ((cmd_reset || cmd_set_high) && !cmd_ack) begin
                for (int i = 0; i < ack_dly; i++) begin
                    @(negedge clk);
                    if (!(cmd_reset || cmd_set_high)) n_viol++;
                end
                cmd_ack = 1'b1;
                if (cmd_reset) begin
                    trip_m[dac_chan] = 0;
                    n_rst++;
                end else begin
                    if (sat(int'(dac_code) + off_g) > trip_m[dac_chan])
                        trip_m[dac_chan] = sat(int'(dac_code) + off_g);
                    last_prog = int'(dac_code);
                    n_set++;
                end
                @(negedge clk);
                cmd_ack = 1'b0;
                if (cmd_reset || cmd_set_high) n_viol++;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #950000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    // Arithmetic reference of one run.
    task automatic ref_run(input int tgt, input int pres, input int off, input int me,
                           output int e_done, output int e_fail, output int e_meas,
                           output int e_rst, output int e_set, output int e_last);
        int t, ap, err;
        t = pres; ap = tgt; e_rst = 0; e_set = 0;
        e_done = 0; e_fail = 0; e_meas = 0; e_last = 0;
        if (tgt < pres) begin t = 0; e_rst++; end
        for (int it = 0; it < ITM; it++) begin
            if (sat(ap + off) > t) t = sat(ap + off);
            e_set++;
            e_last = ap;
            e_meas = t;
            err = t - tgt;
            if (((err < 0) ? -err : err) < me) begin e_done = 1; break; end
            if (it == ITM - 1) begin e_fail = 1; break; end
            ap = sat(ap - err);
            if (err > 0) begin t = 0; e_rst++; end
        end
    endtask

    task automatic run_case(input int ch, input int tgt, input int pres, input int off,
                            input int me, input int ad, input bit poke);
        int e_done, e_fail, e_meas, e_rst, e_set, e_last, guard;
        ref_run(tgt, pres, off, me, e_done, e_fail, e_meas, e_rst, e_set, e_last);
        @(negedge clk);
        off_g = off; ack_dly = ad; n_rst = 0; n_set = 0; n_viol = 0;
        trip_m[ch] = pres;
        chan_sel = 2'(ch); target_code = CW'(tgt); present_code = CW'(pres);
        max_err = CW'(me); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", int'(busy), 1);
        chk("R11 flags cleared", int'(done) + int'(fail), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            chan_sel = 2'((ch % 3) + 1); target_code = CW'(tgt ^ 5); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 40000) begin @(negedge clk); guard++; end
        chk("R7 done", int'(done), e_done);
        chk("R10 fail", int'(fail), e_fail);
        chk("R6 meas_code", int'(meas_code), e_meas);
        chk("R3 R8 reset count", n_rst, e_rst);
        chk("R9 set-higher count", n_set, e_set);
        chk("R4 last programmed code", last_prog, e_last);
        chk("R2 channel", int'(dac_chan), ch);
        chk("R5 handshake violations", n_viol, 0);
    endtask

    initial begin
        int tg [5] = '{3, 17, 31, 46, 60};
        int of [5] = '{-6, -2, 0, 3, 7};
        int k;
        for (int c = 0; c < 4; c++) trip_m[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 busy", int'(busy), 0);
        chk("R1 done/fail", int'(done) + int'(fail), 0);
        chk("R1 commands", int'(cmd_reset) + int'(cmd_set_high), 0);
        chk("R1 dac_code", int'(dac_code), 0);
        // R2: start with channel 0 is ignored.
        chan_sel = 2'd0; target_code = CW'(20); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 ch0 ignored busy", int'(busy), 0);
        chk("R2 ch0 ignored cmds", n_rst + n_set, 0);
        // Main sweep.
        k = 0;
        for (int ti = 0; ti < 5; ti++)
            for (int oi = 0; oi < 5; oi++)
                for (int pi = 0; pi < 2; pi++) begin
                    run_case((k % 3) + 1, tg[ti], (pi == 0) ? 0 : FULL, of[oi],
                             2, k % 3, (k % 7) == 3);
                    k++;
                end
        // Exact convergence with limit 1.
        run_case(2, 25, 10, -3, 1, 1, 1'b0);
        run_case(3, 40, 63, 4, 1, 0, 1'b0);
        // Limit 0 never converges: R10.
        run_case(1, 30, 0, 0, 0, 0, 1'b0);
        // Saturation at full scale and at zero.
        run_case(2, 60, 0, -20, 2, 1, 1'b0);
        run_case(3, 2, 0, 10, 2, 2, 1'b0);
        // R11: done holds while idle.
        run_case(1, 33, 0, 0, 2, 0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R11 done held", int'(done), 1);
        finish_run();
    end

endmodule